// File: doc/BRIEF.md
# Condition-bit to integer set unit

This unit executes a small family of integer instructions that copy a single bit of a 32-bit condition register into a 64-bit general register result. An instruction word arrives with a valid strobe and the current condition register value. The unit checks the opcode fields, picks the condition bit that a 5-bit selector field names, and forms one of three values: zero, one, or all ones. Four variants cover the two result magnitudes (one or all ones) and the two senses (normal or inverted).

One clock after a valid instruction, the unit presents the destination register index, the result and a write enable. An instruction word that the unit does not recognise raises an illegal flag and produces no write. No other architectural state is touched.

Instruction fields use the numbering where bit 0 is the most significant bit. In `in_insn[31:0]` terms the fields are: primary opcode `[31:26]`, destination `[25:21]`, bit selector `[20:16]`, unused `[15:11]`, extended opcode `[10:1]` and unused `[0]`.

Top module: `cbset_unit`

## Requirements
- R1: When `in_valid` is 1, `in_insn[31:26]` is 31 and `in_insn[10:1]` is one of 0x180, 0x1A0, 0x1C0 or 0x1E0, the next cycle shows `out_wen`=1, `out_illegal`=0 and `out_rt` = `in_insn[25:21]`.
- R2: Extended opcode 0x180 gives a result of 1 when the selected condition bit is 1, and 0 when it is 0.
- R3: Extended opcode 0x1A0 gives a result of 0 when the selected condition bit is 1, and 1 when it is 0.
- R4: Extended opcode 0x1C0 gives a result of all ones (64 bits) when the selected condition bit is 1, and 0 when it is 0.
- R5: Extended opcode 0x1E0 gives a result of 0 when the selected condition bit is 1, and all ones when it is 0.
- R6: The selector `in_insn[20:16]` = k picks `in_cr[31-k]`, so k=0 is the most significant condition bit.
- R7: A valid word with a primary opcode other than 31, or with an extended opcode outside the four codes, gives `out_illegal`=1 and `out_wen`=0 in the next cycle, and leaves `out_result` and `out_rt` unchanged.
- R8: The unused bits `in_insn[15:11]` and `in_insn[0]` have no effect on the result, index, write enable or illegal flag.
- R9: Synchronous active-high `rst` clears `out_wen`, `out_illegal`, `out_result` and `out_rt` at the next edge. This holds even when `in_valid` is 1 in the same cycle.
- R10: A cycle with `in_valid`=0 gives `out_wen`=0 and `out_illegal`=0 in the next cycle, and `out_result` and `out_rt` keep their values.
- R11: The result uses the `in_cr` value present in the same cycle as the instruction. Back-to-back instructions each produce their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| in_insn | input | 32 | Instruction word |
| in_cr | input | 32 | Current condition register value |
| out_wen | output | 1 | Write the result to register `out_rt` |
| out_rt | output | 5 | Destination register index |
| out_result | output | 64 | Result value |
| out_illegal | output | 1 | Previous valid word was not recognised |

## Verification
Two things can happen in the same cycle. A reset can arrive together with a valid legal instruction, and a new instruction can arrive while the condition register changes under back-to-back issue. The bench drives a legal set instruction with reset held high and expects every output to be cleared, with no write. It then issues two consecutive instructions with different condition register values and expects each result to follow the register value of its own cycle.

// File: rtl/cbset_pkg.sv
package cbset_pkg;

    parameter int unsigned INSN_W = 32;
    parameter int unsigned CR_W   = 32;
    parameter int unsigned XLEN   = 64;
    parameter int unsigned RIDX_W = 5;
    parameter int unsigned PO_W   = 6;
    parameter int unsigned XO_W   = 10;
    localparam int unsigned SEL_W = $clog2(CR_W);

    localparam logic [PO_W-1:0] PO_CRGROUP = 6'd31;
    localparam logic [XO_W-1:0] XO_ONE      = 10'h180;
    localparam logic [XO_W-1:0] XO_ONE_INV  = 10'h1A0;
    localparam logic [XO_W-1:0] XO_MASK     = 10'h1C0;
    localparam logic [XO_W-1:0] XO_MASK_INV = 10'h1E0;

    // bit 1: result magnitude is all ones; bit 0: sense inverted
    typedef enum logic [1:0] {
        SK_ONE      = 2'b00,
        SK_ONE_INV  = 2'b01,
        SK_MASK     = 2'b10,
        SK_MASK_INV = 2'b11
    } set_kind_e;

    typedef struct packed {
        logic                legal;
        set_kind_e           kind;
        logic [RIDX_W-1:0]   rt;
        logic [SEL_W-1:0]    sel;
    } dec_t;

    function automatic logic kind_is_mask(set_kind_e k);
        return (k == SK_MASK) || (k == SK_MASK_INV);
    endfunction

    function automatic logic kind_is_inv(set_kind_e k);
        return (k == SK_ONE_INV) || (k == SK_MASK_INV);
    endfunction

endpackage

// File: rtl/cbset_decode.sv
module cbset_decode
    import cbset_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    // big-endian field numbering mapped to little-endian vector indices
    localparam int unsigned PO_LSB = INSN_W - PO_W;
    localparam int unsigned RT_LSB = PO_LSB - RIDX_W;
    localparam int unsigned BI_LSB = RT_LSB - SEL_W;
    localparam int unsigned XO_LSB = 1;

    logic [PO_W-1:0] po;
    logic [XO_W-1:0] xo;
    logic            xo_hit;
    set_kind_e       kind;

    assign po = insn[PO_LSB +: PO_W];
    assign xo = insn[XO_LSB +: XO_W];

    always_comb begin
        xo_hit = 1'b1;
        kind   = SK_ONE;
        case (xo)
            XO_ONE:      kind = SK_ONE;
            XO_ONE_INV:  kind = SK_ONE_INV;
            XO_MASK:     kind = SK_MASK;
            XO_MASK_INV: kind = SK_MASK_INV;
            default:     xo_hit = 1'b0;
        endcase
    end

    assign dec.legal = (po == PO_CRGROUP) && xo_hit;
    assign dec.kind  = kind;
    assign dec.rt    = insn[RT_LSB +: RIDX_W];
    assign dec.sel   = insn[BI_LSB +: SEL_W];

endmodule

// File: rtl/cbset_crsel.sv
module cbset_crsel
    import cbset_pkg::*;
(
    input  logic [CR_W-1:0]  cr,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_o
);
    // selector 0 names the most significant bit
    logic [CR_W-1:0] cr_rev;

    for (genvar g = 0; g < CR_W; g++) begin : g_rev
        assign cr_rev[g] = cr[CR_W-1-g];
    end

    assign bit_o = cr_rev[sel];

endmodule

// File: rtl/cbset_form.sv
module cbset_form
    import cbset_pkg::*;
(
    input  logic            cbit,
    input  set_kind_e       kind,
    output logic [XLEN-1:0] result
);
    logic hit;
    logic wide;

    assign hit  = cbit ^ kind_is_inv(kind);
    assign wide = hit & kind_is_mask(kind);

    assign result[0] = hit;
    for (genvar g = 1; g < XLEN; g++) begin : g_upper
        assign result[g] = wide;
    end

endmodule

// File: rtl/cbset_unit.sv
module cbset_unit
    import cbset_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_insn,
    input  logic [CR_W-1:0]   in_cr,
    output logic              out_wen,
    output logic [RIDX_W-1:0] out_rt,
    output logic [XLEN-1:0]   out_result,
    output logic              out_illegal
);
    dec_t            dec;
    logic            cbit;
    logic [XLEN-1:0] value;

    cbset_decode u_dec (
        .insn (in_insn),
        .dec  (dec)
    );

    cbset_crsel u_sel (
        .cr    (in_cr),
        .sel   (dec.sel),
        .bit_o (cbit)
    );

    cbset_form u_form (
        .cbit   (cbit),
        .kind   (dec.kind),
        .result (value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_wen     <= 1'b0;
            out_illegal <= 1'b0;
            out_rt      <= '0;
            out_result  <= '0;
        end else begin
            out_wen     <= in_valid & dec.legal;
            out_illegal <= in_valid & ~dec.legal;
            if (in_valid && dec.legal) begin
                out_rt     <= dec.rt;
                out_result <= value;
            end
        end
    end

endmodule

// File: rtl/cbset_unit_chk.sv
module cbset_unit_chk
    import cbset_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [INSN_W-1:0] in_insn,
    input logic [CR_W-1:0]   in_cr,
    input logic              out_wen,
    input logic [RIDX_W-1:0] out_rt,
    input logic [XLEN-1:0]   out_result,
    input logic              out_illegal
);
    p_legal_writes_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[31:26] == 6'd31 && in_insn[10:1] == 10'h180)
        |=> (out_wen && !out_illegal && out_rt == $past(in_insn[25:21])));

    p_result_shape_r4: assert property (@(posedge clk) disable iff (rst)
        out_wen |-> (out_result == '0 || out_result == 64'd1 || out_result == '1));

    p_bad_po_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[31:26] != 6'd31) |=> (out_illegal && !out_wen));

    p_bad_po_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_insn[31:26] != 6'd31) |=> ($stable(out_result) && $stable(out_rt)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_wen && !out_illegal && $stable(out_result)));

    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(out_wen && out_illegal));

endmodule

bind cbset_unit cbset_unit_chk chk_i (.*);

// File: tb/cbset_unit_tb_top.sv
module cbset_unit_tb_top;
    import cbset_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [9:0]  xo;
        logic [4:0]  rt;
        logic [4:0]  bi;
        logic [31:0] cr;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{10'h180, 5'd3,  5'd10, 32'h0020_0000, 64'd1, 8'd2},  // R2 bit set
        '{10'h180, 5'd4,  5'd10, 32'hFFDF_FFFF, 64'd0, 8'd2},  // R2 bit clear
        '{10'h1A0, 5'd5,  5'd0,  32'h8000_0000, 64'd0, 8'd3},  // R3 bit set
        '{10'h1A0, 5'd6,  5'd0,  32'h7FFF_FFFF, 64'd1, 8'd3},  // R3 bit clear
        '{10'h1C0, 5'd7,  5'd31, 32'h0000_0001, ONES,  8'd4},  // R4 bit set
        '{10'h1C0, 5'd8,  5'd31, 32'hFFFF_FFFE, 64'd0, 8'd4},  // R4 bit clear
        '{10'h1E0, 5'd9,  5'd16, 32'h0000_8000, 64'd0, 8'd5},  // R5 bit set
        '{10'h1E0, 5'd31, 5'd16, 32'hFFFF_7FFF, ONES,  8'd5},  // R5 bit clear
        '{10'h180, 5'd0,  5'd5,  32'h0400_0000, 64'd1, 8'd6},  // R6 selector 5
        '{10'h1C0, 5'd1,  5'd27, 32'h0000_0010, ONES,  8'd6}   // R6 selector 27
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [31:0] in_cr = '0;
    logic        out_wen;
    logic [4:0]  out_rt;
    logic [63:0] out_result;
    logic        out_illegal;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    cbset_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_insn     (in_insn),
        .in_cr       (in_cr),
        .out_wen     (out_wen),
        .out_rt      (out_rt),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] rt, logic [4:0] bi,
                                       logic [4:0] rsv, logic [9:0] xo, logic lsb);
        return {po, rt, bi, rsv, xo, lsb};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge register it, sample at the next falling edge
    task automatic issue(logic [31:0] insn, logic [31:0] cr);
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = insn;
        in_cr    = cr;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [63:0] held_res;
        logic [4:0]  held_rt;

        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 wen after reset", 64'(out_wen), 64'd0);
        check("R9 illegal after reset", 64'(out_illegal), 64'd0);
        check("R9 result after reset", out_result, 64'd0);
        check("R9 rt after reset", 64'(out_rt), 64'd0);
        rst = 1'b0;

        // table walk: R1..R6
        for (int i = 0; i < NVEC; i++) begin
            issue(mk(6'd31, VECS[i].rt, VECS[i].bi, 5'd0, VECS[i].xo, 1'b0), VECS[i].cr);
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), out_result, VECS[i].exp);
            check($sformatf("R1 vec %0d rt", i), 64'(out_rt), 64'(VECS[i].rt));
            check($sformatf("R1 vec %0d wen", i), 64'(out_wen), 64'd1);
            check($sformatf("R1 vec %0d illegal", i), 64'(out_illegal), 64'd0);
        end

        // R10 idle cycle after valid: flags drop, values hold
        held_res = out_result;
        held_rt  = out_rt;
        @(negedge clk);
        check("R10 wen idle", 64'(out_wen), 64'd0);
        check("R10 illegal idle", 64'(out_illegal), 64'd0);
        check("R10 result hold", out_result, held_res);
        check("R10 rt hold", 64'(out_rt), 64'(held_rt));

        // R7 wrong primary opcode
        issue(mk(6'd30, 5'd12, 5'd0, 5'd0, 10'h180, 1'b0), 32'hFFFF_FFFF);
        check("R7 bad po illegal", 64'(out_illegal), 64'd1);
        check("R7 bad po wen", 64'(out_wen), 64'd0);
        check("R7 bad po result unchanged", out_result, held_res);
        check("R7 bad po rt unchanged", 64'(out_rt), 64'(held_rt));

        // R7 extended opcode near a legal code, and zero
        issue(mk(6'd31, 5'd13, 5'd0, 5'd0, 10'h181, 1'b0), 32'hFFFF_FFFF);
        check("R7 bad xo illegal", 64'(out_illegal), 64'd1);
        check("R7 bad xo wen", 64'(out_wen), 64'd0);
        issue(mk(6'd31, 5'd14, 5'd0, 5'd0, 10'h000, 1'b0), 32'hFFFF_FFFF);
        check("R7 zero xo illegal", 64'(out_illegal), 64'd1);
        check("R7 zero xo result unchanged", out_result, held_res);

        // R8 unused fields set
        issue(mk(6'd31, 5'd20, 5'd2, 5'h1F, 10'h1C0, 1'b1), 32'h2000_0000);
        check("R8 result unused set", out_result, ONES);
        check("R8 rt unused set", 64'(out_rt), 64'd20);
        check("R8 wen unused set", 64'(out_wen), 64'd1);
        check("R8 illegal unused set", 64'(out_illegal), 64'd0);
        issue(mk(6'd31, 5'd21, 5'd2, 5'h15, 10'h1A0, 1'b1), 32'hDFFF_FFFF);
        check("R8 reversed unused set", out_result, 64'd1);

        // R11 back to back with condition register change
        @(negedge clk);
        in_valid = 1'b1;
        in_insn  = mk(6'd31, 5'd22, 5'd0, 5'd0, 10'h180, 1'b0);
        in_cr    = 32'h8000_0000;
        @(negedge clk);
        check("R11 first result", out_result, 64'd1);
        check("R11 first rt", 64'(out_rt), 64'd22);
        in_insn  = mk(6'd31, 5'd23, 5'd0, 5'd0, 10'h180, 1'b0);
        in_cr    = 32'h0000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 second result", out_result, 64'd0);
        check("R11 second rt", 64'(out_rt), 64'd23);
        check("R11 second wen", 64'(out_wen), 64'd1);

        // R9 reset together with a legal valid instruction
        issue(mk(6'd31, 5'd25, 5'd0, 5'd0, 10'h1C0, 1'b0), 32'h8000_0000);
        check("R4 pre-reset result", out_result, ONES);
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        in_insn  = mk(6'd31, 5'd26, 5'd0, 5'd0, 10'h1C0, 1'b0);
        in_cr    = 32'h8000_0000;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        check("R9 reset+valid wen", 64'(out_wen), 64'd0);
        check("R9 reset+valid illegal", 64'(out_illegal), 64'd0);
        check("R9 reset+valid result", out_result, 64'd0);
        check("R9 reset+valid rt", 64'(out_rt), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule